// File: doc/BRIEF.md
# Sample and Frame Index Test Pattern Source

This block is a debug data source that takes the place of converter samples at the head of a receive path. It is one of the selectable input modes of that path, next to the filtered and the pass-through sources. On every enabled clock it emits a beat of several complex samples. The real field of each sample holds that sample's position within its frame. The imaginary field holds the index of the current frame. Downstream capture and checking logic can then prove sample continuity, frame boundaries and transfer ordering from the data alone.

A capture trigger restarts both counts from zero. The enable input pauses the pattern without losing its place. The valid, frame-start and frame-end qualifiers go through the same fixed delay as the sample data. A capture stage therefore sees the frame start on exactly the beat that carries sample 0. Lane count, frame length, field widths and the alignment delay are all parameters.

Top module: `sfc_pattern_gen`

## Requirements
- R1: On a valid beat, lane k (k = 0..LANES-1) carries in its real field the value LANES*b + k, where b is the beat number within the frame. Over one frame the real fields therefore cover 0 to FRAME_LEN-1 in order. Lane k occupies `pat_data[k*2*SAMP_W +: 2*SAMP_W]`, with the real field in the low SAMP_W bits and the imaginary field in the high SAMP_W bits.
- R2: On a valid beat, every lane carries the current frame index, zero-extended, in its imaginary field. The index rises by one after the beat that holds sample FRAME_LEN-1.
- R3: A high `trig` clears both the beat and the frame count and produces no valid beat in its own cycle, even when `en` is high. The next enabled beat carries sample 0 of frame 0.
- R4: The frame index is FRAME_W bits wide and wraps from 2^FRAME_W-1 back to 0.
- R5: `pat_sof` is high only on the valid beat that holds sample 0. `pat_eof` is high only on the valid beat that holds sample FRAME_LEN-1.
- R6: While `en` is low (and `trig` is low), no valid beat is produced and both counts hold. The next enabled beat continues from where the pattern stopped.
- R7: Whenever `pat_valid` is low, `pat_data`, `pat_sof` and `pat_eof` are all zero.
- R8: After reset, `pat_valid`, `pat_sof`, `pat_eof` and `pat_data` are zero, and the first enabled beat is sample 0 of frame 0.
- R9: The beat from an enabled cycle appears at the outputs exactly ALIGN_DLY clocks later. Its data and its three qualifiers belong to that same beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the pattern by one beat this cycle |
| trig | input | 1 | Capture trigger; clears both counts |
| pat_data | output | LANES*2*SAMP_W | Packed complex lanes (real low, imaginary high per lane) |
| pat_valid | output | 1 | Beat qualifier |
| pat_sof | output | 1 | Beat holds sample 0 of a frame |
| pat_eof | output | 1 | Beat holds the last sample of a frame |

## Verification
The bench builds the block with four lanes, a 32-sample frame (eight beats), a 4-bit frame index and a four-cycle alignment delay. With these values a plain run covers every beat position and a full wrap of the frame index in about 140 cycles. Every cycle is compared against an arithmetic model. Pauses in the enable, triggers in mid-frame and triggers that arrive together with the enable then reach each boundary of the counting and qualifier logic within a short run.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef struct packed {
      logic valid;
      logic sof;
      logic eof;
   } sfc_qual_t;

   localparam int unsigned QUAL_W = 3;

endpackage

// File: rtl/sfc_count.sv
module sfc_count #(
   parameter int unsigned BEATS   = 128,
   parameter int unsigned FRAME_W = 16,
   localparam int unsigned BW     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               trig,
   output logic [BW-1:0]      beat,
   output logic [FRAME_W-1:0] frame
);

   localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat  <= '0;
         frame <= '0;
      end else if (trig) begin
         beat  <= '0;
         frame <= '0;
      end else if (en) begin
         if (beat == LAST_BEAT) begin
            beat  <= '0;
            frame <= frame + 1'b1;
         end else begin
            beat  <= beat + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sfc_lanes.sv
module sfc_lanes #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned SAMP_W  = 16,
   parameter int unsigned BW      = 7,
   parameter int unsigned FRAME_W = 16,
   localparam int unsigned DW     = LANES * 2 * SAMP_W
) (
   input  logic               act,
   input  logic [BW-1:0]      beat,
   input  logic [FRAME_W-1:0] frame,
   output logic [DW-1:0]      data
);

   logic [SAMP_W-1:0] base;
   assign base = SAMP_W'(beat) * SAMP_W'(LANES);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SAMP_W-1:0] re;
      logic [SAMP_W-1:0] im;
      assign re = act ? (base + SAMP_W'(k)) : '0;
      assign im = act ? SAMP_W'(frame) : '0;
      assign data[k*2*SAMP_W +: 2*SAMP_W] = {im, re};
   end

endmodule

// File: rtl/sfc_align.sv
module sfc_align #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_pipe
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
         end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
         end
      end
      assign dout = stage[DEPTH-1];
   end

endmodule

// File: rtl/sfc_pattern_gen.sv
module sfc_pattern_gen
   import sfc_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned FRAME_LEN = 512,
   parameter int unsigned SAMP_W    = 16,
   parameter int unsigned FRAME_W   = 16,
   parameter int unsigned ALIGN_DLY = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        trig,
   output logic [LANES*2*SAMP_W-1:0]   pat_data,
   output logic                        pat_valid,
   output logic                        pat_sof,
   output logic                        pat_eof
);

   localparam int unsigned BEATS = FRAME_LEN / LANES;
   localparam int unsigned BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int unsigned DW    = LANES * 2 * SAMP_W;
   localparam int unsigned AW    = DW + QUAL_W;

   if (LANES < 1) begin : g_err_lanes
      $error("sfc_pattern_gen: LANES must be at least 1");
   end
   if (FRAME_LEN % LANES != 0) begin : g_err_div
      $error("sfc_pattern_gen: FRAME_LEN must be a multiple of LANES");
   end
   if ($clog2(FRAME_LEN) > SAMP_W) begin : g_err_samp
      $error("sfc_pattern_gen: SAMP_W too narrow for sample index");
   end
   if (FRAME_W > SAMP_W) begin : g_err_frame
      $error("sfc_pattern_gen: FRAME_W must not exceed SAMP_W");
   end

   logic [BW-1:0]      beat;
   logic [FRAME_W-1:0] frame;
   logic               act;
   logic [DW-1:0]      data0;
   sfc_qual_t          qual0;
   sfc_qual_t          qual_o;
   logic [AW-1:0]      align_out;

   assign act = en & ~trig;

   sfc_count #(
      .BEATS   (BEATS),
      .FRAME_W (FRAME_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .trig  (trig),
      .beat  (beat),
      .frame (frame)
   );

   sfc_lanes #(
      .LANES   (LANES),
      .SAMP_W  (SAMP_W),
      .BW      (BW),
      .FRAME_W (FRAME_W)
   ) u_lanes (
      .act   (act),
      .beat  (beat),
      .frame (frame),
      .data  (data0)
   );

   always_comb begin
      qual0.valid = act;
      qual0.sof   = act && (beat == '0);
      qual0.eof   = act && (beat == BW'(BEATS - 1));
   end

   sfc_align #(
      .W     (AW),
      .DEPTH (ALIGN_DLY)
   ) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({qual0, data0}),
      .dout  (align_out)
   );

   assign qual_o    = sfc_qual_t'(align_out[AW-1:DW]);
   assign pat_data  = align_out[DW-1:0];
   assign pat_valid = qual_o.valid;
   assign pat_sof   = qual_o.sof;
   assign pat_eof   = qual_o.eof;

endmodule

// File: rtl/sfc_pattern_gen_chk.sv
module sfc_pattern_gen_chk #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned FRAME_LEN = 512,
   parameter int unsigned SAMP_W    = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [LANES*2*SAMP_W-1:0] pat_data,
   input logic                      pat_valid,
   input logic                      pat_sof,
   input logic                      pat_eof
);

   localparam int unsigned LW = 2 * SAMP_W;

   logic [SAMP_W-1:0] re0, im0, re_last;
   assign re0     = pat_data[SAMP_W-1:0];
   assign im0     = pat_data[SAMP_W +: SAMP_W];
   assign re_last = pat_data[(LANES-1)*LW +: SAMP_W];

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_valid |-> (pat_data == '0 && !pat_sof && !pat_eof));

   // R5
   sof_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_sof |-> (re0 == '0));

   // R5
   eof_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_eof |-> (re_last == SAMP_W'(FRAME_LEN - 1)));

   // R1
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_valid && $past(pat_valid) && !pat_sof) |-> (re0 == $past(re0) + SAMP_W'(LANES)));

   // R2
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_valid && $past(pat_valid) && !pat_sof) |-> (im0 == $past(im0)));

   for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
      // R1
      lane_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pat_valid |-> (pat_data[k*LW +: SAMP_W] == re0 + SAMP_W'(k)));
      // R2
      lane_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pat_valid |-> (pat_data[k*LW + SAMP_W +: SAMP_W] == im0));
   end

endmodule

bind sfc_pattern_gen sfc_pattern_gen_chk #(
   .LANES     (LANES),
   .FRAME_LEN (FRAME_LEN),
   .SAMP_W    (SAMP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pat_data  (pat_data),
   .pat_valid (pat_valid),
   .pat_sof   (pat_sof),
   .pat_eof   (pat_eof)
);

// File: tb/sfc_pattern_gen_test.sv
module sfc_pattern_gen_test;

   localparam int unsigned LANES     = 4;
   localparam int unsigned FRAME_LEN = 32;
   localparam int unsigned SAMP_W    = 16;
   localparam int unsigned FRAME_W   = 4;
   localparam int unsigned D         = 4;
   localparam int unsigned BEATS     = FRAME_LEN / LANES;
   localparam int unsigned DW        = LANES * 2 * SAMP_W;
   localparam int unsigned NFR       = 1 << FRAME_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          trig = 1'b0;
   logic [DW-1:0] pat_data;
   logic          pat_valid, pat_sof, pat_eof;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sfc_pattern_gen #(
      .LANES     (LANES),
      .FRAME_LEN (FRAME_LEN),
      .SAMP_W    (SAMP_W),
      .FRAME_W   (FRAME_W),
      .ALIGN_DLY (D)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .trig      (trig),
      .pat_data  (pat_data),
      .pat_valid (pat_valid),
      .pat_sof   (pat_sof),
      .pat_eof   (pat_eof)
   );

   // bench model state
   int            m_beat  = 0;
   int            m_frame = 0;
   logic [DW-1:0] p_data [D];
   logic          p_v [D];
   logic          p_s [D];
   logic          p_e [D];

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [SAMP_W-1:0] lane_re(input int k);
      return pat_data[k*2*SAMP_W +: SAMP_W];
   endfunction

   function automatic logic [SAMP_W-1:0] lane_im(input int k);
      return pat_data[k*2*SAMP_W + SAMP_W +: SAMP_W];
   endfunction

   task automatic step(input logic e, input logic t);
      logic          v0;
      logic [DW-1:0] d0;
      en   = e;
      trig = t;
      v0   = e && !t;
      d0   = '0;
      if (v0) begin
         for (int k = 0; k < LANES; k++) begin
            d0[k*2*SAMP_W +: SAMP_W]          = SAMP_W'(m_beat * LANES + k);
            d0[k*2*SAMP_W + SAMP_W +: SAMP_W] = SAMP_W'(m_frame);
         end
      end
      @(posedge clk);
      for (int i = D - 1; i > 0; i--) begin
         p_data[i] = p_data[i-1];
         p_v[i]    = p_v[i-1];
         p_s[i]    = p_s[i-1];
         p_e[i]    = p_e[i-1];
      end
      p_data[0] = d0;
      p_v[0]    = v0;
      p_s[0]    = v0 && (m_beat == 0);
      p_e[0]    = v0 && (m_beat == BEATS - 1);
      if (t) begin
         m_beat  = 0;
         m_frame = 0;
      end else if (e) begin
         if (m_beat == BEATS - 1) begin
            m_beat  = 0;
            m_frame = (m_frame + 1) % NFR;
         end else begin
            m_beat = m_beat + 1;
         end
      end
      #5;
      check("R9 R6 valid", DW'(pat_valid), DW'(p_v[D-1]));
      check("R5 sof", DW'(pat_sof), DW'(p_s[D-1]));
      check("R5 eof", DW'(pat_eof), DW'(p_e[D-1]));
      if (p_v[D-1]) check("R1 R2 R4 data", pat_data, p_data[D-1]);
      else          check("R7 idle data", pat_data, p_data[D-1]);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) begin
         p_data[i] = '0; p_v[i] = 1'b0; p_s[i] = 1'b0; p_e[i] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #5;
      // R8: reset state
      check("R8 reset valid", DW'(pat_valid), '0);
      check("R8 reset data", pat_data, '0);
      check("R8 reset qual", DW'({pat_sof, pat_eof}), '0);
      rst_n = 1'b1;

      // R9: latency of exactly D clocks
      step(1'b1, 1'b0);
      for (int i = 0; i < D - 2; i++) step(1'b0, 1'b0);
      check("R9 early valid", DW'(pat_valid), '0);
      step(1'b0, 1'b0);
      check("R9 arrival valid", DW'(pat_valid), DW'(1));
      check("R8 first sample", DW'({lane_im(0), lane_re(0)}), '0);

      // continuous run across a full frame-index wrap (R4)
      step(1'b0, 1'b1);
      for (int i = 0; i < NFR * BEATS; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < D - 1; i++) step(1'b0, 1'b0);
      check("R4 wrap frame", DW'(lane_im(LANES-1)), '0);
      check("R4 wrap sample", DW'(lane_re(0)), '0);
      check("R4 wrap sof", DW'(pat_sof), DW'(1));

      // R6: pause holds position
      step(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < D - 1; i++) step(1'b0, 1'b0);
      check("R6 resume index", DW'(lane_re(0)), DW'(3 * LANES));
      check("R6 resume valid", DW'(pat_valid), DW'(1));

      // gapped enable pattern
      for (int i = 0; i < 60; i++) step((i % 3) != 0, 1'b0);

      // R3: trigger in mid-frame with enable high
      for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      for (int i = 0; i < D - 1; i++) step(1'b0, 1'b0);
      check("R3 restart sample", DW'(lane_re(0)), '0);
      check("R3 restart frame", DW'(lane_im(0)), '0);
      check("R3 restart sof", DW'(pat_sof), DW'(1));

      // back-to-back triggers and mixed traffic
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      for (int i = 0; i < 40; i++) step((i % 5) != 2, (i == 23));
      for (int i = 0; i < D; i++) step(1'b0, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule